// File: doc/BRIEF.md
# Indexed Compare/Capture Register Array

This block is the register file behind a four-channel compare/capture unit attached to a 16-bit timer. A processor reaches it through a narrow window of byte-wide bus locations. One location holds a channel pointer. Three more locations act as ports onto the control byte, the low data byte and the high data byte of whichever channel the pointer names. A fifth location holds the per-channel event flags.

A 16-bit value is written in two bus writes. The high byte goes into a single holding byte that all channels share. The low-byte write then moves the whole word into the selected channel in one clock cycle. The timer's compare and capture logic sit outside this block. They report events through one strobe per channel, and they supply the value to be captured. Each strobe raises that channel's flag. The flags are gated by per-channel enable bits and by a global enable, and the result forms one combined interrupt.

The bus read data is combinational from the stored state. The bus reset is asynchronous and active low. Its release is synchronised inside the block, so internal state leaves reset two clock edges after the reset input rises.

Top module: `ccap_regfile`

## Requirements
- R1: The bus locations are: 0 = channel pointer, 1 = control port, 2 = data-low port, 3 = data-high port, 4 = flag register. Locations 5 to 7 read as zero, and writes to them change no state.
- R2: The pointer keeps only the low 2 bits of the byte written and reads back zero-extended. The control, data-low and data-high ports reach only the channel the pointer selects, and the other channels stay unchanged.
- R3: A write to the data-high port stores the byte in one holding byte shared by all channels. No channel's data changes.
- R4: A write to the data-low port of a channel in compare mode loads {holding byte, written byte} into that channel's 16-bit data. The new value is visible on the next clock cycle.
- R5: The holding byte keeps its value across data-low writes, so repeated data-low writes reuse the last high byte written.
- R6: Control bit 0 set to 1 puts a channel in capture mode. Data-low writes to a capture-mode channel are ignored.
- R7: An event strobe sets that channel's flag, which appears at bit i of location 4 for channel i. Writing 1 to a flag bit clears it, and writing 0 leaves it alone. When a strobe and a clear hit the same cycle, the flag stays set.
- R8: The interrupt output is high exactly when the global enable input is high and at least one set flag has its channel's control bit 1 set.
- R9: An event strobe on a capture-mode channel loads the capture value input into that channel's data. On a compare-mode channel the strobe leaves the data unchanged.
- R10: A read of the data-high port returns the selected channel's stored high byte, not the holding byte.
- R11: Reset clears the pointer, every control byte, every data word, the holding byte and all flags. As a result every location reads 0 and the interrupt is low.
- R12: Control bits 2 to 7 are stored per channel and read back unchanged through the control port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 3 | Bus location |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data for bus_addr (combinational) |
| evt_strobe | input | 4 | Per-channel compare/capture event strobe |
| cap_value | input | 16 | Timer value taken by capture-mode channels |
| irq_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Combined channel interrupt |
| chan_capture | output | 4 | Per-channel capture-mode select, for the pin logic |
| chan_data | output | 64 | All channel data words, channel i at bits 16*i+15 : 16*i |

## Verification
The bench builds the block with its default parameters: four channels, byte-wide ports and 16-bit data. At this size every channel, every pointer value (including pointer bytes with high bits set) and every bus location can be swept in full. Each data commit is compared against the whole data bus output, so a write that lands in the wrong channel shows up at once. The small channel count also lets every flag, enable and global-enable combination on the interrupt path be reached, along with the cycle where an event and a clear collide.

// File: rtl/ccap_pkg.sv
package ccap_pkg;
  localparam int          LOC_W        = 3;
  localparam logic [2:0]  LOC_INDEX    = 3'd0;
  localparam logic [2:0]  LOC_CTRL     = 3'd1;
  localparam logic [2:0]  LOC_DLO      = 3'd2;
  localparam logic [2:0]  LOC_DHI      = 3'd3;
  localparam logic [2:0]  LOC_FLAG     = 3'd4;
  localparam int          CTRL_CAP_BIT = 0;
  localparam int          CTRL_IE_BIT  = 1;
endpackage

// File: rtl/ccap_window.sv
module ccap_window
  import ccap_pkg::*;
#(
  parameter  int NUM_CH = 4,
  parameter  int BYTE_W = 8,
  localparam int IDX_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              wr_en,
  input  logic [LOC_W-1:0]  addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [IDX_W-1:0]  sel_idx_o,
  output logic [BYTE_W-1:0] shadow_o,
  output logic [NUM_CH-1:0] wr_ctrl_o,
  output logic [NUM_CH-1:0] wr_lo_o,
  output logic              wr_flag_o
);
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BYTE_W-1:0] shadow_q, shadow_d;
  logic              idx_we, hi_we, lo_we, ctrl_we;

  assign idx_we    = wr_en && (addr == LOC_INDEX);
  assign ctrl_we   = wr_en && (addr == LOC_CTRL);
  assign lo_we     = wr_en && (addr == LOC_DLO);
  assign hi_we     = wr_en && (addr == LOC_DHI);
  assign wr_flag_o = wr_en && (addr == LOC_FLAG);

  always_comb begin
    idx_d    = idx_q;
    shadow_d = shadow_q;
    if (idx_we) idx_d    = wdata[IDX_W-1:0];
    if (hi_we)  shadow_d = wdata;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      idx_q    <= '0;
      shadow_q <= '0;
    end else begin
      idx_q    <= idx_d;
      shadow_q <= shadow_d;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign wr_ctrl_o[g] = ctrl_we && (idx_q == IDX_W'(g));
    assign wr_lo_o[g]   = lo_we   && (idx_q == IDX_W'(g));
  end

  assign sel_idx_o = idx_q;
  assign shadow_o  = shadow_q;

  // R5: holding byte only moves on a data-high write
  a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!arst_n)
    !hi_we |=> $stable(shadow_o));
  // R2: pointer only moves on a pointer write
  a_r2_idx_hold: assert property (@(posedge clk) disable iff (!arst_n)
    !idx_we |=> $stable(sel_idx_o));
endmodule

// File: rtl/ccap_channel.sv
module ccap_channel
  import ccap_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              wr_ctrl,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] shadow,
  input  logic              evt,
  input  logic [DATA_W-1:0] cap_val,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] data_o
);
  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              cap_mode;

  assign cap_mode = ctrl_q[CTRL_CAP_BIT];

  always_comb begin
    ctrl_d = ctrl_q;
    data_d = data_q;
    if (wr_ctrl) ctrl_d = wdata;
    if (cap_mode) begin
      if (evt) data_d = cap_val;
    end else if (wr_lo) begin
      data_d = {shadow, wdata};
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      data_q <= data_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign data_o = data_q;

  // R4: compare-mode commit of holding byte and written byte
  a_r4_commit: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_lo && !ctrl_o[CTRL_CAP_BIT]) |=> (data_o == $past({shadow, wdata})));
  // R6: capture-mode channels ignore data writes
  a_r6_cap_ignore: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_lo && ctrl_o[CTRL_CAP_BIT] && !evt) |=> $stable(data_o));
  // R9: capture strobe loads the timer value
  a_r9_capture: assert property (@(posedge clk) disable iff (!arst_n)
    (evt && ctrl_o[CTRL_CAP_BIT]) |=> (data_o == $past(cap_val)));
  // R9: compare-mode strobe leaves data alone
  a_r9_cmp_keep: assert property (@(posedge clk) disable iff (!arst_n)
    (evt && !ctrl_o[CTRL_CAP_BIT] && !wr_lo) |=> $stable(data_o));
endmodule

// File: rtl/ccap_flags.sv
module ccap_flags #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [NUM_CH-1:0] evt,
  input  logic              wr_flag,
  input  logic [NUM_CH-1:0] clr_mask,
  input  logic [NUM_CH-1:0] ie,
  input  logic              glob_en,
  output logic [NUM_CH-1:0] flags_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] flags_q, flags_d, clr_eff;

  always_comb begin
    clr_eff = wr_flag ? clr_mask : '0;
    flags_d = (flags_q & ~clr_eff) | evt;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;
  assign irq_o   = glob_en && |(flags_q & ie);

  // R7: a strobe always leaves its flag set, even against a clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!arst_n)
    (|evt) |=> ((flags_o & $past(evt)) == $past(evt)));
  // R7: write-one clear takes effect where no strobe collides
  a_r7_w1c: assert property (@(posedge clk) disable iff (!arst_n)
    wr_flag |=> ((flags_o & $past(clr_mask & ~evt)) == '0));
  // R8: interrupt needs a set flag
  a_r8_irq_src: assert property (@(posedge clk) disable iff (!arst_n)
    irq_o |-> (|flags_o));
endmodule

// File: rtl/ccap_regfile.sv
module ccap_regfile
  import ccap_pkg::*;
#(
  parameter  int NUM_CH = 4,
  parameter  int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W,
  localparam int IDX_W  = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [LOC_W-1:0]         bus_addr,
  input  logic [BYTE_W-1:0]        bus_wdata,
  output logic [BYTE_W-1:0]        bus_rdata,
  input  logic [NUM_CH-1:0]        evt_strobe,
  input  logic [DATA_W-1:0]        cap_value,
  input  logic                     irq_en,
  output logic                     irq,
  output logic [NUM_CH-1:0]        chan_capture,
  output logic [NUM_CH*DATA_W-1:0] chan_data
);
  logic [1:0]        rst_sync_q;
  logic              arst_n;
  logic [IDX_W-1:0]  sel_idx;
  logic [BYTE_W-1:0] shadow;
  logic [NUM_CH-1:0] wr_ctrl, wr_lo, ie, flags;
  logic              wr_flag;
  logic [BYTE_W-1:0] ctrl_arr [NUM_CH];
  logic [DATA_W-1:0] data_arr [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign arst_n = rst_sync_q[1];

  ccap_window #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_window (
    .clk(clk), .arst_n(arst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .sel_idx_o(sel_idx), .shadow_o(shadow),
    .wr_ctrl_o(wr_ctrl), .wr_lo_o(wr_lo), .wr_flag_o(wr_flag)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ccap_channel #(.BYTE_W(BYTE_W)) u_ch (
      .clk(clk), .arst_n(arst_n), .wr_ctrl(wr_ctrl[c]), .wr_lo(wr_lo[c]),
      .wdata(bus_wdata), .shadow(shadow), .evt(evt_strobe[c]),
      .cap_val(cap_value), .ctrl_o(ctrl_arr[c]), .data_o(data_arr[c])
    );
    assign ie[c]                        = ctrl_arr[c][CTRL_IE_BIT];
    assign chan_capture[c]              = ctrl_arr[c][CTRL_CAP_BIT];
    assign chan_data[c*DATA_W +: DATA_W] = data_arr[c];
  end

  ccap_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk(clk), .arst_n(arst_n), .evt(evt_strobe), .wr_flag(wr_flag),
    .clr_mask(bus_wdata[NUM_CH-1:0]), .ie(ie), .glob_en(irq_en),
    .flags_o(flags), .irq_o(irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      LOC_INDEX: bus_rdata = {{(BYTE_W-IDX_W){1'b0}}, sel_idx};
      LOC_CTRL:  bus_rdata = ctrl_arr[sel_idx];
      LOC_DLO:   bus_rdata = data_arr[sel_idx][BYTE_W-1:0];
      LOC_DHI:   bus_rdata = data_arr[sel_idx][DATA_W-1:BYTE_W];
      LOC_FLAG:  bus_rdata = {{(BYTE_W-NUM_CH){1'b0}}, flags};
      default:   bus_rdata = '0;
    endcase
  end

  // R3: a data-high write alone moves no channel data
  a_r3_shadow_only: assert property (@(posedge clk) disable iff (!arst_n)
    (bus_wr && bus_addr == LOC_DHI && evt_strobe == '0) |=> $stable(chan_data));
  // R8: interrupt never rises while globally disabled
  a_r8_glob_gate: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(irq) |-> irq_en);
  // R1: unused locations change no channel state
  a_r1_hole_write: assert property (@(posedge clk) disable iff (!arst_n)
    (bus_wr && bus_addr > LOC_FLAG && evt_strobe == '0) |=> ($stable(chan_data) && $stable(flags)));
endmodule

// File: tb/ccap_regfile_tb_top.sv
module ccap_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [3:0]  evt_strobe;
  logic [15:0] cap_value;
  logic        irq_en;
  logic        irq;
  logic [3:0]  chan_capture;
  logic [63:0] chan_data;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_data [4];
  logic [7:0]  exp_ctrl [4];
  logic [7:0]  hold;
  logic [7:0]  rd;

  always #10 clk = ~clk;

  ccap_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_strobe(evt_strobe),
    .cap_value(cap_value), .irq_en(irq_en), .irq(irq),
    .chan_capture(chan_capture), .chan_data(chan_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdb(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic [3:0] e);
    @(negedge clk);
    evt_strobe = e;
    @(negedge clk);
    evt_strobe = '0;
  endtask

  function automatic logic [63:0] pack_exp();
    return {exp_data[3], exp_data[2], exp_data[1], exp_data[0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    evt_strobe = '0; cap_value = '0; irq_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: everything reads zero after reset
    for (int a = 0; a < 8; a++) begin
      rdb(3'(a), rd);
      chk("R11 reset read", rd, 8'h00);
    end
    chk("R11 reset irq", irq, 1'b0);
    chk("R11 reset data", chan_data, 64'h0);
    for (int c = 0; c < 4; c++) begin exp_data[c] = '0; exp_ctrl[c] = '0; end
    hold = '0;

    // R2/R12: pointer low bits, control bytes per channel
    for (int c = 0; c < 4; c++) begin
      wr(3'd0, 8'hFC | 8'(c));
      rdb(3'd0, rd);
      chk("R2 pointer readback", rd, 8'(c));
      exp_ctrl[c] = 8'hA0 | 8'(c << 2);
      wr(3'd1, exp_ctrl[c]);
    end
    for (int c = 0; c < 4; c++) begin
      wr(3'd0, 8'(c));
      rdb(3'd1, rd);
      chk("R12 ctrl readback", rd, exp_ctrl[c]);
    end

    // R3/R4/R5/R10: data commit sweep over channels and patterns
    for (int c = 0; c < 4; c++) begin
      wr(3'd0, 8'(c));
      for (int p = 0; p < 4; p++) begin
        hold = 8'(8'h13 * (p + 1)) ^ 8'(c << 6);
        wr(3'd3, hold);
        chk("R3 hi write leaves data", chan_data, pack_exp());
        rdb(3'd3, rd);
        chk("R10 hi read is stored", rd, exp_data[c][15:8]);
        wr(3'd2, 8'(8'h5A + p * 17 + c));
        exp_data[c] = {hold, 8'(8'h5A + p * 17 + c)};
        chk("R4 commit word", chan_data, pack_exp());
        rdb(3'd2, rd);
        chk("R4 lo readback", rd, exp_data[c][7:0]);
        rdb(3'd3, rd);
        chk("R10 hi readback", rd, exp_data[c][15:8]);
        wr(3'd2, 8'(~p));
        exp_data[c] = {hold, 8'(~p)};
        chk("R5 reused high byte", chan_data, pack_exp());
      end
    end

    // R1: unused locations ignore writes and read zero
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 8'hFF);
      rdb(3'(a), rd);
      chk("R1 hole read", rd, 8'h00);
    end
    chk("R1 hole data", chan_data, pack_exp());
    rdb(3'd4, rd);
    chk("R1 hole flags", rd, 8'h00);

    // R6/R9: capture mode on channel 2
    wr(3'd0, 8'd2);
    exp_ctrl[2] = 8'h01;
    wr(3'd1, exp_ctrl[2]);
    chk("R6 capture select out", chan_capture, 4'b0100);
    wr(3'd3, 8'hEE);
    wr(3'd2, 8'h77);
    chk("R6 write ignored", chan_data, pack_exp());
    cap_value = 16'hC0DE;
    pulse(4'b0101);
    exp_data[2] = 16'hC0DE;
    chk("R9 capture load / compare keep", chan_data, pack_exp());
    rdb(3'd4, rd);
    chk("R7 flags set", rd, 8'h05);

    // R7: write-one clear and collision
    wr(3'd4, 8'h01);
    rdb(3'd4, rd);
    chk("R7 w1c", rd, 8'h04);
    wr(3'd4, 8'h00);
    rdb(3'd4, rd);
    chk("R7 zero write keeps", rd, 8'h04);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h06; evt_strobe = 4'b0010;
    @(negedge clk);
    bus_wr = 1'b0; evt_strobe = '0;
    rdb(3'd4, rd);
    chk("R7 set wins", rd, 8'h02);

    // R8: interrupt gating sweep
    wr(3'd0, 8'd1);
    exp_ctrl[1] = 8'h02;
    wr(3'd1, exp_ctrl[1]);
    for (int g = 0; g < 2; g++) begin
      irq_en = g[0];
      #1 chk("R8 gate enabled flag", irq, g[0]);
    end
    wr(3'd4, 8'h02);
    chk("R8 cleared flag", irq, 1'b0);
    pulse(4'b1000);
    chk("R8 flag without enable", irq, 1'b0);
    pulse(4'b0010);
    chk("R8 re-raised", irq, 1'b1);
    irq_en = 1'b0;
    #1 chk("R8 global off", irq, 1'b0);
    chk("R9 compare strobes keep data", chan_data, pack_exp());

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule